// File: doc/BRIEF.md
# Countdown Timer with Interrupt Status

This block is a general-purpose 32-bit countdown timer for a peripheral subsystem. Software sees it through a small 16-bit register bus. The live count appears as a low half-word and a high half-word. A command register starts, stops and soft-resets the counter. A mask register and a write-1-to-clear status register together drive a single level interrupt line.

The count decrements once per tick. A tick is a clock enable that an internal divider derives from the system clock, one enable every `TICK_DIV` cycles. When the count passes zero it wraps to all ones and keeps running. The wrap raises the timer-complete flag, which is bit 7 of the shared status register. The other status bits belong to neighbouring logic, which raises them with one-cycle set pulses on `status_set`.

Top module: `countdown_irq_timer`

## Requirements
- R1: After reset the command register reads 0x0002 (stopped), both count halves read 0x0000, mask and status read 0x0000, and `irq` is low.
- R2: While running, the count drops by one every `TICK_DIV` clock cycles. The divider phase restarts on an accepted start command and on every count write, so the first decrement lands `TICK_DIV` cycles after that write.
- R3: A decrement from zero loads 0xFFFF_FFFF, counting continues, and status bit 7 is set on that same clock edge.
- R4: Command register (address 0): bit 0 is start and bit 1 is stop. Start sets the running flag (read bit 0) and clears the stopped flag (read bit 1). Stop does the opposite and freezes the count. When both bits are written together, stop takes precedence.
- R5: Writing address 1 replaces the low 16 bits of the count, and writing address 2 replaces the high 16 bits. The other half is kept, the running state is unchanged, and a running timer continues from the new value.
- R6: `bus_rdata` returns, one clock after `bus_addr` is presented, the register contents before that edge. Count reads give the live count. Addresses 5 to 7 read 0x0000, and writes to them change nothing.
- R7: Command bit 2 (soft reset) halts the timer and sets the soft-reset flag (read bit 2). While that flag is set, a command write without bit 2 only clears the flag.
- R8: Status register (address 4): writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R9: Mask register (address 3): bit 15 always stores 0 when written.
- R10: `irq` is high exactly when (mask AND status) is nonzero, and it changes on the same edge as those registers.
- R11: If a set pulse and a write-1 clear hit the same status bit in the same cycle, the bit ends up set.
- R12: Every bit of `status_set` that is high in a cycle sets the corresponding status bit at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register index |
| bus_wr | input | 1 | Write strobe for bus_wdata |
| bus_wdata | input | REG_W | Write data |
| bus_rdata | output | REG_W | Registered read data |
| status_set | input | REG_W | One-cycle set pulses from other status sources |
| irq | output | 1 | Masked interrupt level |

## Verification
The bench builds the block with `TICK_DIV` = 3. At that value a decrement falls every third edge, so every read lands in a different divider phase, and the expected counts follow from edge counting alone. With small loaded counts, the wrap through zero happens within a dozen cycles, so the underflow reload, the continued counting after it and the timing of the interrupt all fall inside a short run. Mask and status behaviour, including simultaneous set and clear, comes from a vector table applied while the counter is stopped.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [2:0] {
    A_CMD    = 3'd0,
    A_CNT_LO = 3'd1,
    A_CNT_HI = 3'd2,
    A_MASK   = 3'd3,
    A_STAT   = 3'd4
  } reg_addr_e;

  localparam int CMD_START = 0;
  localparam int CMD_STOP  = 1;
  localparam int CMD_SRST  = 2;
  localparam int UF_BIT    = 7;
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
  parameter int DIV = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic restart,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] ph_q;

  always_ff @(posedge clk) begin
    if (rst || restart || !en) begin
      ph_q <= '0;
    end else if (ph_q == LAST) begin
      ph_q <= '0;
    end else begin
      ph_q <= ph_q + 1'b1;
    end
  end

  assign tick = en & ~restart & (ph_q == LAST);

  generate
    if (DIV > 1) begin : g_spacing
      AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R2
    end
  endgenerate
endmodule

// File: rtl/tmr_down_cnt.sv
module tmr_down_cnt #(
  parameter int HALF_W = 16,
  parameter int NHALF  = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       run,
  input  logic                       tick,
  input  logic [NHALF-1:0]           ld,
  input  logic [HALF_W-1:0]          wdata,
  output logic [HALF_W*NHALF-1:0]    count,
  output logic                       underflow
);
  localparam int CNT_W = HALF_W * NHALF;

  logic [HALF_W-1:0] half_q [NHALF];
  logic              dec;
  logic [CNT_W-1:0]  cnt_dec;

  assign dec       = run & tick & ~(|ld);
  assign cnt_dec   = count - 1'b1;
  assign underflow = dec & (count == '0);

  generate
    for (genvar h = 0; h < NHALF; h++) begin : g_half
      always_ff @(posedge clk) begin
        if (rst) begin
          half_q[h] <= '0;
        end else if (ld[h]) begin
          half_q[h] <= wdata;
        end else if (dec) begin
          half_q[h] <= cnt_dec[h*HALF_W +: HALF_W];
        end
      end
      assign count[h*HALF_W +: HALF_W] = half_q[h];
    end
  endgenerate

  AST_UF_RELOAD: assert property (@(posedge clk) disable iff (rst)
    underflow |=> (&count)); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!run && !(|ld)) |=> $stable(count)); // R4
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    (run && tick && !(|ld) && count != '0) |=> (count == $past(count) - 1'b1)); // R2
endmodule

// File: rtl/tmr_irq_stat.sv
module tmr_irq_stat #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_mask,
  input  logic         wr_stat,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] set_vec,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] stat_q,
  output logic         irq_q
);
  logic [W-1:0] clr_vec;
  logic [W-1:0] mask_d;
  logic [W-1:0] stat_d;

  always_comb begin
    clr_vec = wr_stat ? wdata : '0;
    stat_d  = (stat_q & ~clr_vec) | set_vec;
    mask_d  = mask_q;
    if (wr_mask) begin
      mask_d = {1'b0, wdata[W-2:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      mask_q <= mask_d;
      stat_q <= stat_d;
      irq_q  <= |(mask_d & stat_d);
    end
  end

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    wr_stat |=> ((stat_q & $past(wdata) & ~$past(set_vec)) == '0)); // R8
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (|set_vec) |=> ((stat_q & $past(set_vec)) == $past(set_vec))); // R11
  AST_MASK_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
    wr_mask |=> !mask_q[W-1]); // R9
  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
    irq_q == (|(mask_q & stat_q))); // R10
endmodule

// File: rtl/countdown_irq_timer.sv
module countdown_irq_timer #(
  parameter int REG_W    = 16,
  parameter int ADDR_W   = 3,
  parameter int TICK_DIV = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic [REG_W-1:0]  status_set,
  output logic              irq
);
  import tmr_pkg::*;

  localparam int NHALF = 2;
  localparam int CNT_W = REG_W * NHALF;

  logic wr_cmd, wr_lo, wr_hi, wr_mask, wr_stat;
  logic run_q, stop_q, srst_q;
  logic srst_exit, cmd_act, start_acc;
  logic tick, restart, underflow;
  logic [CNT_W-1:0] count;
  logic [REG_W-1:0] mask_q, stat_q, set_vec, rd_d, rd_q;

  assign wr_cmd  = bus_wr && (bus_addr == ADDR_W'(A_CMD));
  assign wr_lo   = bus_wr && (bus_addr == ADDR_W'(A_CNT_LO));
  assign wr_hi   = bus_wr && (bus_addr == ADDR_W'(A_CNT_HI));
  assign wr_mask = bus_wr && (bus_addr == ADDR_W'(A_MASK));
  assign wr_stat = bus_wr && (bus_addr == ADDR_W'(A_STAT));

  // Soft-reset flag pending: the next plain command only releases it.
  assign srst_exit = wr_cmd && srst_q && !bus_wdata[CMD_SRST];
  assign cmd_act   = wr_cmd && !srst_exit;
  assign start_acc = cmd_act && bus_wdata[CMD_START]
                     && !bus_wdata[CMD_STOP] && !bus_wdata[CMD_SRST];
  assign restart   = start_acc || wr_lo || wr_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      stop_q <= 1'b1;
      srst_q <= 1'b0;
    end else if (srst_exit) begin
      srst_q <= 1'b0;
    end else if (cmd_act) begin
      if (bus_wdata[CMD_SRST]) begin
        srst_q <= 1'b1;
        run_q  <= 1'b0;
        stop_q <= 1'b1;
      end else if (bus_wdata[CMD_STOP]) begin
        run_q  <= 1'b0;
        stop_q <= 1'b1;
      end else if (bus_wdata[CMD_START]) begin
        run_q  <= 1'b1;
        stop_q <= 1'b0;
      end
    end
  end

  tmr_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk     (clk),
    .rst     (rst),
    .en      (run_q),
    .restart (restart),
    .tick    (tick)
  );

  tmr_down_cnt #(.HALF_W(REG_W), .NHALF(NHALF)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .run       (run_q),
    .tick      (tick),
    .ld        ({wr_hi, wr_lo}),
    .wdata     (bus_wdata),
    .count     (count),
    .underflow (underflow)
  );

  always_comb begin
    set_vec         = status_set;
    set_vec[UF_BIT] = status_set[UF_BIT] | underflow;
  end

  tmr_irq_stat #(.W(REG_W)) u_stat (
    .clk     (clk),
    .rst     (rst),
    .wr_mask (wr_mask),
    .wr_stat (wr_stat),
    .wdata   (bus_wdata),
    .set_vec (set_vec),
    .mask_q  (mask_q),
    .stat_q  (stat_q),
    .irq_q   (irq)
  );

  always_comb begin
    rd_d = '0;
    case (bus_addr)
      ADDR_W'(A_CMD): begin
        rd_d[CMD_START] = run_q;
        rd_d[CMD_STOP]  = stop_q;
        rd_d[CMD_SRST]  = srst_q;
      end
      ADDR_W'(A_CNT_LO): rd_d = count[REG_W-1:0];
      ADDR_W'(A_CNT_HI): rd_d = count[CNT_W-1:REG_W];
      ADDR_W'(A_MASK):   rd_d = mask_q;
      ADDR_W'(A_STAT):   rd_d = stat_q;
      default:           rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else begin
      rd_q <= rd_d;
    end
  end

  assign bus_rdata = rd_q;

  AST_RUN_STOP_EXCL: assert property (@(posedge clk) disable iff (rst)
    run_q != stop_q); // R4
  AST_SRST_HALTS: assert property (@(posedge clk) disable iff (rst)
    srst_q |-> !run_q); // R7
  AST_SRST_RELEASE: assert property (@(posedge clk) disable iff (rst)
    srst_exit |=> (!srst_q && !run_q)); // R7
  AST_UF_FLAGS: assert property (@(posedge clk) disable iff (rst)
    underflow |=> stat_q[UF_BIT]); // R3
endmodule

// File: tb/sim_countdown_irq_timer.sv
module sim_countdown_irq_timer;
  localparam int DIV = 3;

  typedef struct packed {
    logic [15:0] mask;
    logic [15:0] set;
    logic [15:0] clr;
    logic [15:0] exp_stat;
    logic [15:0] exp_mask;
    logic        exp_irq;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{16'h0000, 16'h0011, 16'h0000, 16'h0011, 16'h0000, 1'b0},
    '{16'h0010, 16'h0000, 16'h0000, 16'h0011, 16'h0010, 1'b1},
    '{16'h0010, 16'h0000, 16'h0010, 16'h0001, 16'h0010, 1'b0},
    '{16'h8001, 16'h0000, 16'h0000, 16'h0001, 16'h0001, 1'b1},
    '{16'h8000, 16'h8000, 16'h0000, 16'h8001, 16'h0000, 1'b0},
    '{16'h0001, 16'h0001, 16'h0001, 16'h8001, 16'h0001, 1'b1},
    '{16'hFFFF, 16'h0000, 16'h8001, 16'h0000, 16'h7FFF, 1'b0},
    '{16'h0100, 16'h0300, 16'h0000, 16'h0300, 16'h0100, 1'b1},
    '{16'h0100, 16'h0000, 16'h0200, 16'h0100, 16'h0100, 1'b1},
    '{16'h0000, 16'h0000, 16'hFFFF, 16'h0000, 16'h0000, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  bus_addr = 3'd0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = 16'h0000;
  logic [15:0] bus_rdata;
  logic [15:0] status_set = 16'h0000;
  logic        irq;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  countdown_irq_timer #(.REG_W(16), .ADDR_W(3), .TICK_DIV(DIV)) u0 (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .status_set (status_set),
    .irq        (irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R2 watchdog: actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] r;
    logic [15:0] frozen;
    idle(3);
    rst = 1'b0;
    idle(1);

    // R1 reset state
    check("R1 irq", 32'(irq), 32'h0);
    rd(3'd0, r); check("R1 cmd", 32'(r), 32'h0002);
    rd(3'd1, r); check("R1 cnt_lo", 32'(r), 32'h0000);
    rd(3'd2, r); check("R1 cnt_hi", 32'(r), 32'h0000);
    rd(3'd3, r); check("R1 mask", 32'(r), 32'h0000);
    rd(3'd4, r); check("R1 status", 32'(r), 32'h0000);

    // R8 R9 R10 R11 R12 vector table
    for (int i = 0; i < 10; i++) begin
      wr(3'd3, VECS[i].mask);
      status_set = VECS[i].set;
      wr(3'd4, VECS[i].clr);
      status_set = 16'h0000;
      check($sformatf("R10 irq vec %0d", i), 32'(irq), 32'(VECS[i].exp_irq));
      rd(3'd4, r); check($sformatf("R8 R11 R12 status vec %0d", i), 32'(r), 32'(VECS[i].exp_stat));
      rd(3'd3, r); check($sformatf("R9 mask vec %0d", i), 32'(r), 32'(VECS[i].exp_mask));
    end

    // R5 load while stopped, R4 frozen
    wr(3'd2, 16'h0001);
    wr(3'd1, 16'h0005);
    idle(5);
    rd(3'd1, r); check("R5 lo while stopped", 32'(r), 32'h0005);
    rd(3'd2, r); check("R5 hi while stopped", 32'(r), 32'h0001);

    // R2 R6 counting
    wr(3'd0, 16'h0001);
    idle(5);
    rd(3'd1, r); check("R2 R6 lo after 5 cycles", 32'(r), 32'h0004);
    rd(3'd2, r); check("R6 hi live", 32'(r), 32'h0001);
    rd(3'd1, r); check("R2 lo after 7 cycles", 32'(r), 32'h0003);

    // R4 stop freezes
    wr(3'd0, 16'h0002);
    idle(10);
    rd(3'd1, r); check("R4 frozen lo", 32'(r), 32'h0002);
    rd(3'd2, r); check("R4 frozen hi", 32'(r), 32'h0001);
    wr(3'd0, 16'h0003);
    rd(3'd0, r); check("R4 stop wins over start", 32'(r), 32'h0002);
    rd(3'd1, r); check("R4 still frozen", 32'(r), 32'h0002);

    // R3 underflow
    wr(3'd3, 16'h0080);
    wr(3'd2, 16'h0000);
    wr(3'd1, 16'h0002);
    wr(3'd0, 16'h0001);
    idle(8);
    check("R10 irq before underflow", 32'(irq), 32'h0);
    rd(3'd4, r); check("R3 status before underflow", 32'(r), 32'h0000);
    check("R3 R10 irq at underflow", 32'(irq), 32'h1);
    rd(3'd4, r); check("R3 status bit 7", 32'(r), 32'h0080);
    rd(3'd2, r); check("R3 reload hi", 32'(r), 32'hFFFF);
    rd(3'd1, r); check("R3 reload lo", 32'(r), 32'hFFFF);
    rd(3'd1, r); check("R3 keeps counting", 32'(r), 32'hFFFE);
    wr(3'd4, 16'h0080);
    check("R8 R10 irq after clear", 32'(irq), 32'h0);
    rd(3'd4, r); check("R8 status cleared", 32'(r), 32'h0000);

    // R5 load while running
    wr(3'd1, 16'h0010);
    idle(4);
    rd(3'd1, r); check("R5 R2 running reload lo", 32'(r), 32'h000F);
    rd(3'd2, r); check("R5 hi kept", 32'(r), 32'hFFFF);

    // R7 soft reset
    wr(3'd0, 16'h0004);
    rd(3'd0, r); check("R7 cmd after soft reset", 32'(r), 32'h0006);
    rd(3'd1, frozen);
    idle(6);
    rd(3'd1, r); check("R7 halted", 32'(r), 32'(frozen));
    wr(3'd0, 16'h0001);
    rd(3'd0, r); check("R7 release only", 32'(r), 32'h0002);
    idle(4);
    rd(3'd1, r); check("R7 still halted", 32'(r), 32'(frozen));
    wr(3'd0, 16'h0001);
    rd(3'd0, r); check("R7 R4 restarted", 32'(r), 32'h0001);
    idle(6);
    rd(3'd1, r); check("R7 R2 counts again", 32'(r), 32'(frozen - 16'd2));

    // R6 unmapped address
    wr(3'd5, 16'h1234);
    rd(3'd5, r); check("R6 unmapped reads zero", 32'(r), 32'h0000);
    rd(3'd3, r); check("R6 unmapped write ignored", 32'(r), 32'h0080);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule